// File: doc/BRIEF.md
# Cache Victim Way Selector

This block picks which way of a set-associative cache receives the next line fill. Normally it rotates a pointer over the ways that are currently enabled. A diagnostic (management) access aimed at an enabled way overrides the rotation. That way becomes the forced victim for the very next access, and the next access uses up the override whether it hits or misses. Software can therefore flush a chosen line with two steps: a management read of the line, then a cacheable read of another block that maps to the same index.

Each access, normal or management, also produces a one-cycle hit or miss pulse for the performance counters. Hits count only in enabled ways. The fill itself always replaces a whole line in the chosen way. The tag and data arrays and the bus side are outside this block. It only reports the way number and a strobe saying a fill victim was chosen.

Top module: `cache_victim_sel`

## Requirements
- R1: An access with `accValid=1`, `accMgmt=1` and `wayEnable[mgmtWay]=1` records `mgmtWay` as the forced victim and drives `overridePending` high from the next cycle.
- R2: The first normal access (`accMgmt=0`) after the override is set clears `overridePending` in the next cycle, whether it hits, misses, or requests a fill.
- R3: A normal access with `fillNeed=1` while an override is pending and the forced way is still enabled gives `victimValid=1` and `victimWay` equal to the forced way in the next cycle.
- R4: Every access, management or normal, gives exactly one of `hitPulse` or `missPulse` for one cycle in the next cycle. It is a hit when `hitVec & wayEnable` is nonzero. With no access, both pulses are low.
- R5: A management access to a disabled way changes neither `overridePending` nor the recorded forced way nor the rotation pointer.
- R6: With no override in force, a fill picks the first enabled way after the rotation pointer, searching upward and wrapping. The pointer then moves to that way. After reset the pointer sits at the last way, so the first fill with all ways enabled picks way 0.
- R7: A fill served by the forced way leaves the rotation pointer unchanged.
- R8: A normal fill request while `wayEnable` is all zero gives no `victimValid`. Instead `noWayErr` goes high for exactly one cycle, in the next cycle, and the pointer is unchanged.
- R9: When `victimValid` is high, the way reported was enabled in the access that selected it.
- R10: A management access never starts a fill: `victimValid` stays low in the next cycle even if `fillNeed=1`.
- R11: After reset `overridePending`, `victimValid`, `hitPulse`, `missPulse` and `noWayErr` are low and `victimWay` is 0.
- R12: If the forced way has been disabled by the time its fill arrives, that fill falls back to rotation as in R6. The override is still consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| accMgmt | input | 1 | The access is a management (diagnostic) access |
| mgmtWay | input | WAYW | Target way of a management access |
| wayEnable | input | WAYS | One enable bit per way |
| hitVec | input | WAYS | Tag-compare hit bit per way |
| fillNeed | input | 1 | The access needs a line fill |
| victimValid | output | 1 | A fill victim was chosen (one cycle) |
| victimWay | output | WAYW | Chosen victim way |
| hitPulse | output | 1 | One-cycle hit indication for counters |
| missPulse | output | 1 | One-cycle miss indication for counters |
| overridePending | output | 1 | A forced victim waits for the next access |
| noWayErr | output | 1 | Fill requested with no way enabled (one cycle) |

## Verification
Every result is a register loaded at the clock edge that samples the access. `victimValid`, `victimWay`, `hitPulse`, `missPulse`, `noWayErr` and the change of `overridePending` therefore appear one cycle after the access and stay for one cycle, except the pending flag, which holds. The bench drives each access on a falling edge and drops `accValid` on the next falling edge. It samples the results at that same falling edge, half a cycle after the edge that loaded them. One-cycle pulses are checked again a cycle later to confirm they fell. Whether the pointer was held or advanced is observed through the victim of a later rotation fill, with the expected way worked out by hand from R6.

// File: rtl/victim_pkg.sv
package victim_pkg;

  // Decisions from the control half, consumed by the datapath half.
  typedef struct packed {
    logic accept;     // an access was taken this cycle
    logic isHit;      // enabled-way hit for the counters
    logic loadForce;  // record management way as forced victim
    logic clearPend;  // normal access consumes a pending override
    logic fillForce;  // fill served by the forced way
    logic fillRot;    // fill served by the rotation search
    logic noWay;      // fill requested with no enabled way
  } ctrlStrobes_t;

endpackage

// File: rtl/cvs_ctrl.sv
module cvs_ctrl
  import victim_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAYW = $clog2(WAYS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            accValid,
  input  logic            accMgmt,
  input  logic [WAYW-1:0] mgmtWay,
  input  logic [WAYS-1:0] wayEnable,
  input  logic [WAYS-1:0] hitVec,
  input  logic            fillNeed,
  input  logic            pendingQ,
  input  logic            forceOk,
  output ctrlStrobes_t    strb
);

  logic [WAYS-1:0] maskedHit;
  logic            anyEnabled;
  logic            mgmtTargetOn;
  logic            wantFill;
  logic            forceUsable;

  // Per-way masking of the tag-compare result.
  for (genvar w = 0; w < WAYS; w++) begin : g_hitMask
    assign maskedHit[w] = hitVec[w] & wayEnable[w];
  end

  assign anyEnabled   = |wayEnable;
  assign mgmtTargetOn = (int'(mgmtWay) < WAYS) && wayEnable[mgmtWay];
  assign wantFill     = accValid && !accMgmt && fillNeed;
  assign forceUsable  = pendingQ && forceOk;

  always_comb begin
    strb           = '0;
    strb.accept    = accValid;
    strb.isHit     = |maskedHit;
    strb.loadForce = accValid && accMgmt && mgmtTargetOn;
    strb.clearPend = accValid && !accMgmt && pendingQ;
    strb.noWay     = wantFill && !anyEnabled;
    strb.fillForce = wantFill && anyEnabled && forceUsable;
    strb.fillRot   = wantFill && anyEnabled && !forceUsable;
  end

  // At most one way of serving a fill request is chosen (R6, R8, R3).
  p_fill_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.fillForce, strb.fillRot, strb.noWay}));

  // Management accesses never produce a fill strobe (R10).
  p_mgmt_no_fill_r10: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accMgmt) |-> !(strb.fillForce || strb.fillRot || strb.noWay));

endmodule

// File: rtl/cvs_datapath.sv
module cvs_datapath
  import victim_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAYW = $clog2(WAYS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobes_t    strb,
  input  logic [WAYW-1:0] mgmtWay,
  input  logic [WAYS-1:0] wayEnable,
  output logic            pendingQ,
  output logic            forceOk,
  output logic            victimValid,
  output logic [WAYW-1:0] victimWay,
  output logic            hitPulse,
  output logic            missPulse,
  output logic            noWayErr
);

  localparam logic [WAYW-1:0] LAST_WAY = WAYW'(WAYS - 1);

  logic [WAYW-1:0] rotPtr;
  logic [WAYW-1:0] forceWay;
  logic [WAYW-1:0] rotPick;

  assign forceOk = wayEnable[forceWay];

  // Rotation search: first enabled way strictly after rotPtr, wrapping.
  // Scanning from the far end lets the nearest candidate win.
  always_comb begin
    rotPick = rotPtr;
    for (int step = WAYS; step >= 1; step--) begin
      int idx;
      idx = int'(rotPtr) + step;
      if (idx >= WAYS) idx = idx - WAYS;
      if (wayEnable[idx]) rotPick = idx[WAYW-1:0];
    end
  end

  // Replacement state.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rotPtr   <= LAST_WAY;
      forceWay <= '0;
      pendingQ <= 1'b0;
    end else begin
      if (strb.loadForce) begin
        forceWay <= mgmtWay;
        pendingQ <= 1'b1;
      end else if (strb.clearPend) begin
        pendingQ <= 1'b0;
      end
      if (strb.fillRot) rotPtr <= rotPick;
    end
  end

  // Registered results.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimValid <= 1'b0;
      victimWay   <= '0;
      hitPulse    <= 1'b0;
      missPulse   <= 1'b0;
      noWayErr    <= 1'b0;
    end else begin
      victimValid <= strb.fillForce || strb.fillRot;
      if (strb.fillForce)    victimWay <= forceWay;
      else if (strb.fillRot) victimWay <= rotPick;
      hitPulse  <= strb.accept && strb.isHit;
      missPulse <= strb.accept && !strb.isHit;
      noWayErr  <= strb.noWay;
    end
  end

  // R1: management to an enabled way raises the pending flag.
  p_force_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadForce |=> pendingQ);

  // R2: a normal access drops the pending flag, hit or miss.
  p_force_consumed_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearPend && !strb.loadForce) |=> !pendingQ);

  // R5: an access that neither loads nor consumes leaves the flag alone.
  p_pending_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadForce && !strb.clearPend) |=> $stable(pendingQ) && $stable(forceWay));

  // R4: exactly one counter pulse per access, none without an access.
  p_one_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> (hitPulse != missPulse));
  p_no_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.accept |=> !hitPulse && !missPulse);

  // R7: a forced fill leaves the rotation pointer where it was.
  p_force_keeps_ptr_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillForce |=> $stable(rotPtr));

  // R8: error flag is a single-cycle pulse and excludes a victim.
  p_err_no_victim_r8: assert property (@(posedge clk) disable iff (!rstN)
    noWayErr |-> !victimValid);

  // R9: the reported victim was enabled when chosen.
  p_victim_enabled_r9: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> ((($past(wayEnable) >> victimWay) & WAYS'(1)) != '0));

endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel
  import victim_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAYW = $clog2(WAYS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            accValid,
  input  logic            accMgmt,
  input  logic [WAYW-1:0] mgmtWay,
  input  logic [WAYS-1:0] wayEnable,
  input  logic [WAYS-1:0] hitVec,
  input  logic            fillNeed,
  output logic            victimValid,
  output logic [WAYW-1:0] victimWay,
  output logic            hitPulse,
  output logic            missPulse,
  output logic            overridePending,
  output logic            noWayErr
);

  ctrlStrobes_t strb;
  logic         pendingQ;
  logic         forceOk;

  cvs_ctrl #(.WAYS(WAYS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .accValid  (accValid),
    .accMgmt   (accMgmt),
    .mgmtWay   (mgmtWay),
    .wayEnable (wayEnable),
    .hitVec    (hitVec),
    .fillNeed  (fillNeed),
    .pendingQ  (pendingQ),
    .forceOk   (forceOk),
    .strb      (strb)
  );

  cvs_datapath #(.WAYS(WAYS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .mgmtWay     (mgmtWay),
    .wayEnable   (wayEnable),
    .pendingQ    (pendingQ),
    .forceOk     (forceOk),
    .victimValid (victimValid),
    .victimWay   (victimWay),
    .hitPulse    (hitPulse),
    .missPulse   (missPulse),
    .noWayErr    (noWayErr)
  );

  assign overridePending = pendingQ;

  // R10: a management access is never followed by a victim strobe.
  p_mgmt_no_victim_r10: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accMgmt) |=> !victimValid);

endmodule

// File: tb/cache_victim_sel_test.sv
`timescale 1ns/1ps
module cache_victim_sel_test;

  localparam int WAYS = 4;
  localparam int WAYW = 2;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            accValid = 1'b0;
  logic            accMgmt = 1'b0;
  logic [WAYW-1:0] mgmtWay = '0;
  logic [WAYS-1:0] wayEnable = '1;
  logic [WAYS-1:0] hitVec = '0;
  logic            fillNeed = 1'b0;
  logic            victimValid;
  logic [WAYW-1:0] victimWay;
  logic            hitPulse;
  logic            missPulse;
  logic            overridePending;
  logic            noWayErr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  cache_victim_sel #(.WAYS(WAYS)) uut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accMgmt(accMgmt),
    .mgmtWay(mgmtWay), .wayEnable(wayEnable), .hitVec(hitVec),
    .fillNeed(fillNeed), .victimValid(victimValid), .victimWay(victimWay),
    .hitPulse(hitPulse), .missPulse(missPulse),
    .overridePending(overridePending), .noWayErr(noWayErr)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Present one access at a falling edge; return at the next falling edge
  // where the registered results of that access are visible.
  task automatic access(input logic mg, input logic [WAYW-1:0] wy,
                        input logic [WAYS-1:0] en, input logic [WAYS-1:0] hv,
                        input logic fl);
    @(negedge clk);
    accValid = 1'b1; accMgmt = mg; mgmtWay = wy;
    wayEnable = en; hitVec = hv; fillNeed = fl;
    @(negedge clk);
    accValid = 1'b0; accMgmt = 1'b0; fillNeed = 1'b0; hitVec = '0;
  endtask

  task automatic fillExpect(input logic [WAYS-1:0] en, input int way, input string tag);
    access(1'b0, '0, en, '0, 1'b1);
    check({tag, " victimValid"}, int'(victimValid), 1);
    check({tag, " victimWay"}, int'(victimWay), way);
  endtask

  task automatic t_reset;  // R11
    check("R11 pending", int'(overridePending), 0);
    check("R11 victimValid", int'(victimValid), 0);
    check("R11 victimWay", int'(victimWay), 0);
    check("R11 pulses", int'({hitPulse, missPulse, noWayErr}), 0);
  endtask

  task automatic t_rotation;  // R6, R4
    fillExpect(4'b1111, 0, "R6 first");
    check("R4 miss", int'(missPulse), 1);
    check("R4 hit low", int'(hitPulse), 0);
    @(negedge clk);
    check("R4 pulse falls", int'({hitPulse, missPulse}), 0);
    fillExpect(4'b1111, 1, "R6 seq");
    fillExpect(4'b1111, 2, "R6 seq");
    fillExpect(4'b1111, 3, "R6 seq");
    fillExpect(4'b1111, 0, "R6 wrap");
    fillExpect(4'b1010, 1, "R6 sparse");
    fillExpect(4'b1010, 3, "R6 sparse");
    fillExpect(4'b1010, 1, "R6 sparse wrap");  // pointer at 1
  endtask

  task automatic t_force_hit;  // R1, R2, R4, R10
    access(1'b1, 2'd2, 4'b1111, 4'b0100, 1'b1);
    check("R1 pending set", int'(overridePending), 1);
    check("R4 mgmt hit", int'(hitPulse), 1);
    check("R10 no victim", int'(victimValid), 0);
    access(1'b0, '0, 4'b1111, 4'b0001, 1'b0);  // normal hit, no fill
    check("R2 consumed by hit", int'(overridePending), 0);
    check("R2 no victim", int'(victimValid), 0);
    fillExpect(4'b1111, 2, "R2 rotation resumes");  // pointer 1 -> 2
  endtask

  task automatic t_force_fill;  // R3, R7
    access(1'b1, 2'd0, 4'b1111, 4'b0000, 1'b0);
    check("R4 mgmt miss", int'(missPulse), 1);
    fillExpect(4'b1111, 0, "R3 forced");
    check("R2 consumed by fill", int'(overridePending), 0);
    fillExpect(4'b1111, 3, "R7 pointer held");  // pointer was 2
  endtask

  task automatic t_disabled_mgmt;  // R5
    access(1'b1, 2'd3, 4'b0111, 4'b0000, 1'b0);
    check("R5 no pending", int'(overridePending), 0);
    access(1'b1, 2'd1, 4'b1111, 4'b0000, 1'b0);
    check("R1 pending way1", int'(overridePending), 1);
    access(1'b1, 2'd3, 4'b0111, 4'b0000, 1'b0);
    check("R5 pending kept", int'(overridePending), 1);
    fillExpect(4'b1111, 1, "R5 forced way kept");
    fillExpect(4'b1111, 0, "R5 pointer kept");  // pointer was 3
  endtask

  task automatic t_no_way;  // R8, R4
    access(1'b0, '0, 4'b0000, 4'b1111, 1'b1);
    check("R8 no victim", int'(victimValid), 0);
    check("R8 error", int'(noWayErr), 1);
    check("R4 masked hit is miss", int'(missPulse), 1);
    @(negedge clk);
    check("R8 error one cycle", int'(noWayErr), 0);
    fillExpect(4'b1111, 1, "R8 pointer unchanged");  // pointer was 0
  endtask

  task automatic t_force_gone;  // R12
    access(1'b1, 2'd2, 4'b1111, 4'b0000, 1'b0);
    check("R1 pending way2", int'(overridePending), 1);
    fillExpect(4'b1011, 3, "R12 fallback");
    check("R12 consumed", int'(overridePending), 0);
  endtask

  task automatic t_mgmt_fill;  // R10
    access(1'b1, 2'd1, 4'b1111, 4'b0000, 1'b1);
    check("R10 mgmt fill ignored", int'(victimValid), 0);
    access(1'b0, '0, 4'b1111, 4'b0000, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_rotation();
    t_force_hit();
    t_force_fill();
    t_disabled_mgmt();
    t_no_way();
    t_force_gone();
    t_mgmt_fill();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule